// File: doc/BRIEF.md
# DMA Event Latch and Clear Logic

This block collects DMA trigger events into a bank of pending flags and decides how each flag is retired. Each event input is a single-cycle pulse synchronous to the block clock. A pulse sets its pending flag, and the flag stays set until one of two things clears it. If the event is enabled, the block offers it as a transfer request, and the flag clears when that request is accepted. If the event is disabled, it is never offered, and software retires it by writing a one to the matching bit of a write-one-to-clear register.

A small register port gives software three things: a read-only view of the pending flags, a read/write enable mask, and the write-only clear register. Among the enabled pending events, a priority picker selects the lowest-numbered one. That event is held in a request slot with a valid/ready handshake. When the slot is accepted, the next candidate loads on the same edge, so requests can be accepted back to back, one per cycle.

Top module: `dma_evt_latch`

## Requirements
- R1: After reset all pending flags are 0, the enable mask is 0 and `req_valid` is 0.
- R2: A pulse on `evt_in[i]` sets pending flag i at the next clock edge. The flag then stays set until it is cleared as R3 or R7 describes.
- R3: A register write to address 2 (clear) clears every pending flag whose bit in `reg_wdata` is 1. Bits written as 0 leave their flags unchanged.
- R4: The read data is combinational from `reg_addr`. Address 0 returns the pending flags, address 1 returns the enable mask (written by a write to address 1), and addresses 2 and 3 return 0.
- R5: An event whose enable bit is 0 is never presented as a request. Its flag stays pending for as long as software leaves it.
- R6: When enabled pending events exist and the slot is free, the lowest-numbered one is presented. `req_valid` and `req_evt` appear on the edge after the pending flag becomes visible.
- R7: When `req_valid` and `req_ready` are both high at an edge, the flag for `req_evt` clears at that edge. On the same edge the slot loads the next lowest enabled pending event, if one exists.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_evt` stays unchanged, even if a lower-numbered event arrives.
- R9: If an event pulse arrives in the same cycle as a software or handshake clear of that flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | NUM_EVT | Event pulses, one bit per event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 pending, 1 enable, 2 clear |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| req_valid | output | 1 | Transfer request present |
| req_evt | output | IDX_W | Event number of the presented request |
| req_ready | input | 1 | Consumer accepts the request |

## Verification
The bench sweeps a single event over all 32 positions twice:
- With the event enabled, the sweep shows that the request carries the right number and that acceptance retires exactly that flag.
- With the event disabled, the sweep shows that no request is raised and that a clear written with every other bit set leaves the flag alone.

A burst of all 32 events with `req_ready` held high is drained. The run must give back-to-back requests in strictly ascending order, which separates a lowest-first picker from any other order.

Three targeted patterns cover the remaining rules:
- A lower-numbered event arrives while a request is stalled, which tests that the slot holds.
- An event pulse coincides with a software clear, and another with an accepting handshake, which tests that the set wins.
- A mixed pattern is written to the enable mask and read back.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
   typedef enum logic [1:0] {
      RA_PEND = 2'd0,
      RA_EN   = 2'd1,
      RA_CLR  = 2'd2,
      RA_RSVD = 2'd3
   } reg_addr_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
   parameter int NUM_EVT = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] set_i,
   input  logic [NUM_EVT-1:0] clr_i,
   output logic [NUM_EVT-1:0] pend_o
);
   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      logic flag_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            flag_q <= 1'b0;
         else if (set_i[i])
            flag_q <= 1'b1;
         else if (clr_i[i])
            flag_q <= 1'b0;
      end
      assign pend_o[i] = flag_q;
   end
endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
   parameter int NUM_EVT = 32,
   parameter int IDX_W   = 5
) (
   input  logic [NUM_EVT-1:0] cand_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o
);
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = NUM_EVT - 1; i >= 0; i--) begin
         if (cand_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/evt_req_slot.sv
module evt_req_slot #(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_any_i,
   input  logic [IDX_W-1:0] load_idx_i,
   input  logic             ready_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             fire_o
);
   logic             valid_q;
   logic [IDX_W-1:0] idx_q;
   logic             take;

   assign take   = !valid_q || ready_i;
   assign fire_o = valid_q && ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         idx_q   <= '0;
      end else if (take) begin
         valid_q <= load_any_i;
         if (load_any_i)
            idx_q <= load_idx_i;
      end
   end

   assign valid_o = valid_q;
   assign idx_o   = idx_q;
endmodule

// File: rtl/dma_evt_latch.sv
module dma_evt_latch
   import dma_evt_pkg::*;
#(
   parameter int NUM_EVT = 32,
   parameter int DATA_W  = 32,
   localparam int IDX_W  = idx_width(NUM_EVT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic               reg_wr,
   input  logic [1:0]         reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               req_valid,
   output logic [IDX_W-1:0]   req_evt,
   input  logic               req_ready
);
   initial begin
      assert (NUM_EVT >= 1 && NUM_EVT <= DATA_W)
         else $error("dma_evt_latch: NUM_EVT must be in 1..DATA_W");
   end

   reg_addr_e              addr;
   logic [NUM_EVT-1:0]     en_q;
   logic [NUM_EVT-1:0]     pend_q;
   logic [NUM_EVT-1:0]     sw_clr;
   logic [NUM_EVT-1:0]     hw_clr;
   logic [NUM_EVT-1:0]     cand;
   logic                   pick_any;
   logic [IDX_W-1:0]       pick_idx;
   logic                   fire;
   logic [DATA_W-1:0]      pend_w;
   logic [DATA_W-1:0]      en_w;

   assign addr = reg_addr_e'(reg_addr);

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= '0;
      else if (reg_wr && addr == RA_EN)
         en_q <= reg_wdata[NUM_EVT-1:0];
   end

   assign sw_clr = (reg_wr && addr == RA_CLR) ? reg_wdata[NUM_EVT-1:0] : '0;

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_hwclr
      assign hw_clr[i] = fire && (req_evt == IDX_W'(i));
   end

   evt_pend_bank #(.NUM_EVT(NUM_EVT)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_in),
      .clr_i  (sw_clr | hw_clr),
      .pend_o (pend_q)
   );

   assign cand = pend_q & en_q & ~sw_clr & ~hw_clr;

   evt_prio_pick #(.NUM_EVT(NUM_EVT), .IDX_W(IDX_W)) u_pick (
      .cand_i (cand),
      .any_o  (pick_any),
      .idx_o  (pick_idx)
   );

   evt_req_slot #(.IDX_W(IDX_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_any_i (pick_any),
      .load_idx_i (pick_idx),
      .ready_i    (req_ready),
      .valid_o    (req_valid),
      .idx_o      (req_evt),
      .fire_o     (fire)
   );

   always_comb begin
      pend_w = '0;
      en_w   = '0;
      pend_w[NUM_EVT-1:0] = pend_q;
      en_w[NUM_EVT-1:0]   = en_q;
      unique case (addr)
         RA_PEND: reg_rdata = pend_w;
         RA_EN:   reg_rdata = en_w;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dma_evt_latch_chk.sv
module dma_evt_latch_chk #(
   parameter int NUM_EVT = 32,
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EVT-1:0] evt_in,
   input logic               reg_wr,
   input logic [1:0]         reg_addr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic [DATA_W-1:0]  reg_rdata,
   input logic               req_valid,
   input logic [IDX_W-1:0]   req_evt,
   input logic               req_ready,
   input logic [NUM_EVT-1:0] pend_q
);
   logic wr_clr;
   assign wr_clr = reg_wr && reg_addr == 2'd2;

   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(evt_in)) == $past(evt_in)));            // R2

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((pend_q & $past(reg_wdata[NUM_EVT-1:0] & ~evt_in)) == '0)); // R3

   AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[1] == 1'b1) |-> (reg_rdata == '0));                     // R4

   AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !evt_in[req_evt]) |=> !pend_q[$past(req_evt)]); // R7

   AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_evt)));   // R8
endmodule

bind dma_evt_latch dma_evt_latch_chk #(
   .NUM_EVT (NUM_EVT),
   .DATA_W  (DATA_W),
   .IDX_W   (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_in    (evt_in),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .req_valid (req_valid),
   .req_evt   (req_evt),
   .req_ready (req_ready),
   .pend_q    (pend_q)
);

// File: tb/sim_dma_evt_latch.sv
module sim_dma_evt_latch;
   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  evt_in = '0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          req_valid;
   logic [4:0]    req_evt;
   logic          req_ready = 1'b0;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dma_evt_latch #(.NUM_EVT(N), .DATA_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_evt(req_evt), .req_ready(req_ready)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      tick();
      reg_wr = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic pulse(input logic [31:0] m);
      evt_in = m;
      tick();
      evt_in = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      bit ok;
      repeat (3) tick();
      rst_n = 1'b1;
      // R1 reset state
      rd(2'd0, v); check("R1 pending", v, 0);
      rd(2'd1, v); check("R1 enable", v, 0);
      check("R1 valid", {31'd0, req_valid}, 0);

      // R4 enable readback and reserved/clear reads
      wr(2'd1, 32'hA5A5_5A5A);
      rd(2'd1, v); check("R4 enable readback", v, 32'hA5A5_5A5A);
      rd(2'd2, v); check("R4 clear reads 0", v, 0);
      rd(2'd3, v); check("R4 reserved reads 0", v, 0);

      // R6 R7 single enabled event sweep
      wr(2'd1, 32'hFFFF_FFFF);
      for (int i = 0; i < N; i++) begin
         pulse(32'd1 << i);
         rd(2'd0, v); check("R2 enabled set", v, 32'd1 << i);
         check("R6 not yet valid", {31'd0, req_valid}, 0);
         tick();
         check("R6 valid", {31'd0, req_valid}, 1);
         check("R6 index", {27'd0, req_evt}, i);
         req_ready = 1'b1;
         tick();
         req_ready = 1'b0;
         rd(2'd0, v); check("R7 cleared on accept", v, 0);
         check("R7 no further request", {31'd0, req_valid}, 0);
      end

      // R6 R7 burst drain, ascending back to back
      pulse(32'hFFFF_FFFF);
      tick();
      req_ready = 1'b1;
      ok = 1'b1;
      for (int k = 0; k < N; k++) begin
         if (!req_valid || req_evt != 5'(k)) ok = 1'b0;
         tick();
      end
      req_ready = 1'b0;
      check("R6 burst ascending back to back", {31'd0, ok}, 1);
      rd(2'd0, v); check("R7 burst drained", v, 0);
      check("R7 burst idle", {31'd0, req_valid}, 0);

      // R8 stall holds against lower arrival
      pulse(32'd1 << 20);
      tick();
      check("R8 first index", {27'd0, req_evt}, 20);
      pulse(32'd1 << 3);
      tick();
      check("R8 held valid", {31'd0, req_valid}, 1);
      check("R8 held index", {27'd0, req_evt}, 20);
      req_ready = 1'b1;
      tick();
      check("R7 next after accept", {27'd0, req_evt}, 3);
      tick();
      req_ready = 1'b0;
      check("R7 idle after two", {31'd0, req_valid}, 0);

      // R9 set wins over handshake clear
      pulse(32'd1 << 7);
      tick();
      check("R9 presented", {27'd0, req_evt}, 7);
      req_ready = 1'b1;
      evt_in = 32'd1 << 7;
      tick();
      evt_in = '0;
      req_ready = 1'b0;
      rd(2'd0, v); check("R9 set wins handshake", v, 32'd1 << 7);
      tick();
      check("R9 represented", {req_valid, 26'd0, req_evt}, {1'b1, 26'd0, 5'd7});
      req_ready = 1'b1;
      tick();
      req_ready = 1'b0;

      // R5 R3 disabled sweep
      wr(2'd1, 32'h0);
      for (int i = 0; i < N; i++) begin
         pulse(32'd1 << i);
         repeat (3) tick();
         check("R5 never requested", {31'd0, req_valid}, 0);
         rd(2'd0, v); check("R5 stays pending", v, 32'd1 << i);
         wr(2'd2, ~(32'd1 << i));
         rd(2'd0, v); check("R3 zero bits no effect", v, 32'd1 << i);
         wr(2'd2, 32'd1 << i);
         rd(2'd0, v); check("R3 one clears", v, 0);
      end

      // R9 set wins over software clear
      pulse(32'd1 << 5);
      evt_in = 32'd1 << 5;
      wr(2'd2, 32'd1 << 5);
      evt_in = '0;
      rd(2'd0, v); check("R9 set wins software clear", v, 32'd1 << 5);
      wr(2'd2, 32'hFFFF_FFFF);
      rd(2'd0, v); check("R3 final clear", v, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule